// File: doc/BRIEF.md
# Seconds Counter with Snapshot Registers

This block keeps a 32-bit binary count of elapsed seconds. The count sits behind a small byte-addressed register window. A one-cycle tick advances it once per second while the oscillator enable is high. A bus front end outside this block decodes the serial protocol. It presents start and stop events, an address load, byte reads and byte writes.

Reads of the four time bytes come from a shadow copy of the counter, not from the live count. The shadow is refreshed when a transaction opens, when it closes, and when the auto-incrementing pointer wraps back to address 0. A multibyte read therefore returns one consistent value while the live counter keeps running. A byte write goes straight into the live counter and emits a one-cycle pulse that restarts the external 1 Hz prescaler.

A small state machine gates all access. Its states are `ST_IDLE` (no transaction), `ST_ACTIVE` (between a start and a stop) and `ST_BLOCKED` (power fail asserted). Its transitions are:
- IDLE→ACTIVE on a start.
- ACTIVE→IDLE on a stop without a start.
- ACTIVE→ACTIVE on a repeated start.
- IDLE or ACTIVE→BLOCKED whenever power fail is high.
- BLOCKED→IDLE once power fail drops.

Top module: `secs_snap_regs`

## Requirements
- R1: With `osc_en` high, each cycle with `tick` high adds exactly 1 to the live counter. With `osc_en` low, `tick` leaves the counter unchanged.
- R2: An accepted write at pointer address 0..3 replaces only that byte of the live counter (address 0 is the least significant byte, address 3 the most significant). A write at addresses 4..8 leaves the counter unchanged.
- R3: When a write to a time byte and a counting tick fall in the same cycle, the written byte takes the written value. The other three bytes take the value of the incremented count.
- R4: Each accepted read or write advances the pointer by one. From the last address (8) the pointer wraps to 0.
- R5: Reads of addresses 0..3 return the shadow copy. The shadow is loaded from the live counter on an accepted start, on an accepted stop, and when the pointer wraps to 0. It holds its value at all other times.
- R6: `rd_data` and `rd_valid` are registered. They change in the cycle after an accepted read, and `rd_valid` is high for that one cycle. Reads of addresses 4..8 return 0x00.
- R7: `presc_rst` is high for exactly the one cycle after each accepted write to addresses 0..3. It stays low after writes to other addresses.
- R8: Reads, writes and address loads are refused, with no effect on counter, pointer or outputs, while `pwr_fail` is high or outside a start..stop transaction.
- R9: The state machine follows the transitions listed above. After power fail drops, a new start is required before any access is accepted.
- R10: After reset the counter, shadow and pointer are 0, the state is idle, and `rd_data`, `rd_valid` and `presc_rst` are 0.
- R11: An accepted address load sets the pointer to `addr_in`. A value above 8 loads 0. An address load outranks a write, and a write outranks a read, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | Oscillator running; qualifies `tick` |
| tick | input | 1 | One-cycle 1 Hz advance strobe |
| pwr_fail | input | 1 | Power-fail indication, blocks access |
| bus_start | input | 1 | Transaction start event |
| bus_stop | input | 1 | Transaction stop event |
| addr_load | input | 1 | Load pointer from `addr_in` |
| addr_in | input | 8 | New pointer value |
| rd_req | input | 1 | Byte read request |
| wr_req | input | 1 | Byte write request |
| wr_data | input | 8 | Byte write data |
| rd_data | output | 8 | Read byte, registered |
| rd_valid | output | 1 | `rd_data` updated this cycle |
| presc_rst | output | 1 | One-cycle prescaler restart pulse |

## Verification
The assertions assume the front end presents at most one of address load, write or read per cycle, and never raises start and stop in the same cycle. The ranked priority exists only as a fallback. The counter checks also assume `tick` is a single-cycle strobe, so an increment lasts one cycle. The stimulus drives each operation for exactly one cycle from the falling edge, never combines start with stop, and raises `tick` only on cycles with no other activity. The one exception is the deliberate tick-with-write case, which the assertions exclude.

// File: rtl/secs_snap_pkg.sv
package secs_snap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_BLOCKED = 2'd2
    } bus_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/sec_ptr.sv
module sec_ptr #(
    parameter int LAST_ADDR = 8,
    parameter int AW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          wrap
);
    logic at_last;

    assign at_last = (ptr == AW'(LAST_ADDR));
    assign wrap    = step && !load && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (step)
            ptr <= at_last ? '0 : ptr + AW'(1);
    end

    // R4: stepping from the last address lands on 0
    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr == AW'(LAST_ADDR)) |=> (ptr == '0));

    // R4: stepping below the last address moves up by one
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr < AW'(LAST_ADDR)) |=> (ptr == $past(ptr) + AW'(1)));
endmodule

// File: rtl/sec_live.sv
module sec_live #(
    parameter int CNT_W = 32,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [7:0]       wr_byte,
    output logic [CNT_W-1:0] live
);
    localparam int NB = CNT_W / 8;

    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] live_n;

    assign inc = live + CNT_W'(tick_en);

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign live_n[g*8 +: 8] = (wr_en && wr_idx == AW'(g)) ? wr_byte : inc[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            live <= '0;
        else
            live <= live_n;
    end

    // R1: a counting tick with no write adds one
    assert_tick_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_en) |=> (live == $past(live) + CNT_W'(1)));

    // R1, R2: without tick or write the count holds
    assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> $stable(live));

    // R2: a write with no tick updates the addressed byte only
    assert_byte_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tick_en && wr_idx == AW'(0)) |=>
            (live[CNT_W-1:8] == $past(live[CNT_W-1:8]) && live[7:0] == $past(wr_byte)));
endmodule

// File: rtl/sec_shadow.sv
module sec_shadow #(
    parameter int CNT_W = 32,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [CNT_W-1:0] live,
    input  logic [AW-1:0]    rd_idx,
    output logic [7:0]       rd_byte
);
    localparam int NB = CNT_W / 8;

    logic [CNT_W-1:0] shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shadow <= '0;
        else if (cap)
            shadow <= live;
    end

    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < NB; i++) begin
            if (rd_idx == AW'(i))
                rd_byte = shadow[i*8 +: 8];
        end
    end

    // R5: shadow changes only on a capture
    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(shadow));

    // R5: a capture copies the live count
    assert_shadow_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (shadow == $past(live)));
endmodule

// File: rtl/secs_snap_regs.sv
module secs_snap_regs
    import secs_snap_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int LAST_ADDR = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       tick,
    input  logic       pwr_fail,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       addr_load,
    input  logic [7:0] addr_in,
    input  logic       rd_req,
    input  logic       wr_req,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       presc_rst
);
    localparam int NB = CNT_W / 8;
    localparam int AW = $clog2(LAST_ADDR + 1);

    bus_state_t       state_q, state_n;
    logic             acc_ok, do_load, do_wr, do_rd, wr_time;
    logic             start_ev, stop_ev, cap, wrap;
    logic [AW-1:0]    ptr, load_val;
    logic [CNT_W-1:0] live;
    logic [7:0]       sh_byte;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pwr_fail)       state_n = ST_BLOCKED;
                else if (bus_start) state_n = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (pwr_fail)                    state_n = ST_BLOCKED;
                else if (bus_stop && !bus_start) state_n = ST_IDLE;
            end
            ST_BLOCKED: begin
                if (!pwr_fail) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // access decode
    always_comb begin
        acc_ok   = (state_q == ST_ACTIVE) && !pwr_fail;
        do_load  = acc_ok && addr_load;
        do_wr    = acc_ok && !addr_load && wr_req;
        do_rd    = acc_ok && !addr_load && !wr_req && rd_req;
        wr_time  = do_wr && (ptr < AW'(NB));
        start_ev = bus_start && !pwr_fail && (state_q != ST_BLOCKED);
        stop_ev  = bus_stop && !pwr_fail && (state_q == ST_ACTIVE);
        cap      = start_ev || stop_ev || wrap;
        load_val = (addr_in > 8'(LAST_ADDR)) ? '0 : addr_in[AW-1:0];
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data   <= 8'h00;
            rd_valid  <= 1'b0;
            presc_rst <= 1'b0;
        end else begin
            rd_valid  <= do_rd;
            presc_rst <= wr_time;
            if (do_rd)
                rd_data <= sh_byte;
        end
    end

    sec_ptr #(.LAST_ADDR(LAST_ADDR), .AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(do_load), .load_val(load_val),
        .step(do_wr || do_rd), .ptr(ptr), .wrap(wrap)
    );

    sec_live #(.CNT_W(CNT_W), .AW(AW)) u_live (
        .clk(clk), .rst_n(rst_n), .tick_en(tick && osc_en), .wr_en(wr_time),
        .wr_idx(ptr), .wr_byte(wr_data), .live(live)
    );

    sec_shadow #(.CNT_W(CNT_W), .AW(AW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .cap(cap), .live(live),
        .rd_idx(ptr), .rd_byte(sh_byte)
    );

    // R8: nothing is read back while blocked
    assert_blocked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCKED) |=> !rd_valid);

    // R9: power fail always leads to the blocked state
    assert_fail_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (state_q == ST_BLOCKED));

    // R9: leaving the blocked state goes to idle
    assert_block_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCKED && !pwr_fail) |=> (state_q == ST_IDLE));

    // R7: a prescaler pulse follows a time-byte write
    assert_presc_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        presc_rst |-> $past(wr_req && acc_ok));

    // R6: a read strobe follows an accepted read
    assert_rd_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req && acc_ok));
endmodule

// File: tb/sim_secs_snap_regs.sv
module sim_secs_snap_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0, tick = 1'b0, pwr_fail = 1'b0;
    logic       bus_start = 1'b0, bus_stop = 1'b0, addr_load = 1'b0;
    logic [7:0] addr_in = 8'h00, wr_data = 8'h00;
    logic       rd_req = 1'b0, wr_req = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, presc_rst;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    secs_snap_regs u0 (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .tick(tick), .pwr_fail(pwr_fail),
        .bus_start(bus_start), .bus_stop(bus_stop), .addr_load(addr_load),
        .addr_in(addr_in), .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .presc_rst(presc_rst)
    );

    localparam int OP_NOP = 0, OP_START = 1, OP_STOP = 2, OP_LOAD = 3, OP_RD = 4, OP_WR = 5;

    // {op[2:0], arg[7:0], expected read byte[7:0]}
    localparam int NV = 19;
    localparam logic [18:0] VEC [0:NV-1] = '{
        {3'd1, 8'h00, 8'h00},  // start
        {3'd5, 8'h11, 8'h00},  // write byte 0
        {3'd5, 8'h22, 8'h00},
        {3'd5, 8'h33, 8'h00},
        {3'd5, 8'h44, 8'h00},
        {3'd3, 8'h00, 8'h00},
        {3'd4, 8'h00, 8'h00},  // shadow still old
        {3'd2, 8'h00, 8'h00},  // stop captures
        {3'd1, 8'h00, 8'h00},
        {3'd3, 8'h00, 8'h00},
        {3'd4, 8'h00, 8'h11},
        {3'd4, 8'h00, 8'h22},
        {3'd4, 8'h00, 8'h33},
        {3'd4, 8'h00, 8'h44},
        {3'd4, 8'h00, 8'h00},  // address 4 reads zero
        {3'd3, 8'h08, 8'h00},
        {3'd4, 8'h00, 8'h00},  // last address, wraps
        {3'd4, 8'h00, 8'h11},  // wrapped to 0
        {3'd2, 8'h00, 8'h00}
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // drive one operation for one cycle, from falling edge to falling edge
    task automatic op(input int code, input logic [7:0] arg, input logic tk);
        bus_start = (code == OP_START);
        bus_stop  = (code == OP_STOP);
        addr_load = (code == OP_LOAD);
        rd_req    = (code == OP_RD);
        wr_req    = (code == OP_WR);
        addr_in   = arg;
        wr_data   = arg;
        tick      = tk;
        @(negedge clk);
        {bus_start, bus_stop, addr_load, rd_req, wr_req, tick} = '0;
    endtask

    task automatic rd_chk(input logic [7:0] exp, input string req);
        op(OP_RD, 8'h00, 1'b0);
        chk(rd_data, exp, req);
        chk({7'd0, rd_valid}, 8'd1, req);
    endtask

    task automatic reopen();
        op(OP_STOP, 8'h00, 1'b0);
        op(OP_START, 8'h00, 1'b0);
        op(OP_LOAD, 8'h00, 1'b0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(rd_data, 8'h00, "R10 rd_data");
        chk({7'd0, rd_valid}, 8'd0, "R10 rd_valid");
        chk({7'd0, presc_rst}, 8'd0, "R10 presc_rst");

        // table: R2 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            op(int'(VEC[i][18:16]), VEC[i][15:8], 1'b0);
            if (int'(VEC[i][18:16]) == OP_RD)
                chk(rd_data, VEC[i][7:0], $sformatf("R5/R4/R6 vector %0d", i));
        end

        // R1: three ticks, then snapshot
        osc_en = 1'b1;
        repeat (3) op(OP_NOP, 8'h00, 1'b1);
        op(OP_START, 8'h00, 1'b0);
        op(OP_LOAD, 8'h00, 1'b0);
        rd_chk(8'h14, "R1 count after three ticks");
        op(OP_NOP, 8'h00, 1'b1);
        chk({7'd0, rd_valid}, 8'd0, "R6 rd_valid single cycle");
        op(OP_LOAD, 8'h00, 1'b0);
        rd_chk(8'h14, "R5 shadow coherent while live runs");
        reopen();
        rd_chk(8'h15, "R5 start captures new count");

        // R1: tick ignored with oscillator off
        osc_en = 1'b0;
        op(OP_NOP, 8'h00, 1'b1);
        reopen();
        rd_chk(8'h15, "R1 tick ignored when osc off");

        // R3: write byte 0 to FF, then byte 1 with a tick in the same cycle
        osc_en = 1'b1;
        op(OP_LOAD, 8'h00, 1'b0);
        op(OP_WR, 8'hFF, 1'b0);
        chk({7'd0, presc_rst}, 8'd1, "R7 pulse after time write");
        op(OP_WR, 8'h55, 1'b1);
        osc_en = 1'b0;
        op(OP_NOP, 8'h00, 1'b0);
        chk({7'd0, presc_rst}, 8'd0, "R7 pulse ends");
        reopen();
        rd_chk(8'h00, "R3 byte0 from carry");
        rd_chk(8'h55, "R3 byte1 written wins");
        rd_chk(8'h33, "R3 byte2 untouched");

        // R7/R2: write at address 5 leaves counter and prescaler alone
        op(OP_LOAD, 8'h05, 1'b0);
        op(OP_WR, 8'hAA, 1'b0);
        chk({7'd0, presc_rst}, 8'd0, "R7 no pulse for address 5");
        reopen();
        rd_chk(8'h00, "R2 counter unchanged by address 5");

        // R8/R9: power fail blocks access
        pwr_fail = 1'b1;
        op(OP_NOP, 8'h00, 1'b0);
        op(OP_LOAD, 8'h00, 1'b0);
        op(OP_WR, 8'h77, 1'b0);
        chk({7'd0, presc_rst}, 8'd0, "R8 write refused in power fail");
        op(OP_RD, 8'h00, 1'b0);
        chk({7'd0, rd_valid}, 8'd0, "R8 read refused in power fail");
        pwr_fail = 1'b0;
        op(OP_NOP, 8'h00, 1'b0);
        op(OP_RD, 8'h00, 1'b0);
        chk({7'd0, rd_valid}, 8'd0, "R9 idle after power fail needs start");
        op(OP_START, 8'h00, 1'b0);
        op(OP_LOAD, 8'h00, 1'b0);
        rd_chk(8'h00, "R8 counter kept through power fail");

        // R11: out-of-range load gives address 0
        op(OP_LOAD, 8'hF0, 1'b0);
        rd_chk(8'h00, "R11 out-of-range load byte0");
        rd_chk(8'h55, "R11 then byte1");
        op(OP_STOP, 8'h00, 1'b0);

        finish_run();
    end
endmodule